// File: doc/BRIEF.md
# Blitter Pixel Source and Mix Datapath

This block forms the value that a 2D drawing engine writes back to one destination pixel. For each accepted pixel it takes a monochrome select bit, host data, blit (frame-buffer read) data and the current destination value. It picks a foreground or a background path. It applies that path's mix function between the chosen source and the destination. It then merges the mixed value with the old destination under a per-bit write mask. The result appears on the output register exactly one clock after the pixel is presented.

A small register port programs the datapath:

- Foreground colour, background colour and write mask.
- A control word holding the foreground source select, the monochrome source select and the two mix codes.
- A fill port that replicates an 8-bit colour across the low three byte lanes of the foreground colour.

After reset the datapath overpaints with the foreground colour, which is all ones, under a full write mask.

Top module: `pix_mix_unit`

## Requirements
- R1: `out_valid` is `px_valid` delayed by exactly one clock. A pixel presented on clock edge k appears on `out_pixel` after edge k. Reset clears `out_valid` and `out_pixel` to 0.
- R2: When `px_valid` is 0, `out_pixel` keeps its previous value.
- R3: The effective monochrome bit is `px_mono` when control bit 2 is 1, and constant 1 when control bit 2 is 0. A value of 1 selects the foreground source and the foreground mix (control bits 7:4). A value of 0 selects the background colour and the background mix (control bits 11:8).
- R4: The foreground source code in control bits 1:0 selects the source: 0 gives the foreground colour, 1 gives `px_host`, 2 gives `px_blit`, and 3 gives the foreground colour.
- R5: Mix code 1 yields the source. Code 2 yields the destination XOR the source. Code 0 and every code from 3 to 15 yield the destination unchanged.
- R6: The output is (mix result AND mask) OR (`px_dst` AND NOT mask), bit by bit.
- R7: Reset loads the following values:
  - foreground colour all ones;
  - background colour zero;
  - write mask all ones;
  - control 0x010, which means foreground colour source, constant monochrome 1, foreground mix source and background mix destination.
- R8: The configuration addresses are 0 for the foreground colour, 1 for the background colour, 2 for the write mask and 3 for the control word, which takes its data from bits 11:0.
- R9: A write to address 4 sets the foreground colour to {8'h00, c, c, c}, where c is `cfg_wdata[7:0]`.
- R10: Writes to addresses 5, 6 and 7 change nothing.
- R11: A write takes effect from the next clock onward. A pixel presented in the same cycle as a write uses the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| px_valid | input | 1 | Pixel accepted this cycle |
| px_mono | input | 1 | Monochrome bit from host data |
| px_host | input | 32 | Host colour data |
| px_blit | input | 32 | Blit source data |
| px_dst | input | 32 | Current destination pixel |
| out_valid | output | 1 | Output pixel valid |
| out_pixel | output | 32 | Pixel to be written |

## Verification
The assertions check several properties on every cycle:

- the one-clock valid pipeline;
- that `out_pixel` holds during idle cycles;
- that every mask-cleared bit carries the old destination;
- that an undefined mix code passes the destination through;
- the byte replication of a fill write.

Only the bench scenarios can show that specific control encodings are decoded correctly. The same holds for the reset context, for XOR behaviour and for the monochrome choice between the foreground and background paths. The bench scenarios also cover the write-versus-pixel ordering within one cycle and the fact that writes to unused addresses leave the output unaffected.

// File: rtl/pix_mix_pkg.sv
`timescale 1ns/1ps
package pix_mix_pkg;
  localparam logic [2:0] ADDR_FG   = 3'd0;
  localparam logic [2:0] ADDR_BG   = 3'd1;
  localparam logic [2:0] ADDR_MASK = 3'd2;
  localparam logic [2:0] ADDR_CTRL = 3'd3;
  localparam logic [2:0] ADDR_FILL = 3'd4;

  localparam logic [1:0] FGS_COLOR = 2'd0;
  localparam logic [1:0] FGS_HOST  = 2'd1;
  localparam logic [1:0] FGS_BLIT  = 2'd2;

  localparam logic [3:0] MIX_DST = 4'd0;
  localparam logic [3:0] MIX_SRC = 4'd1;
  localparam logic [3:0] MIX_XOR = 4'd2;

  typedef struct packed {
    logic [3:0] bg_mix;
    logic [3:0] fg_mix;
    logic       mono_host;
    logic [1:0] fg_src;
  } mix_ctrl_t;

  localparam mix_ctrl_t CTRL_RESET = '{bg_mix: MIX_DST, fg_mix: MIX_SRC,
                                       mono_host: 1'b0, fg_src: FGS_COLOR};
endpackage

// File: rtl/pix_mix_cfg.sv
`timescale 1ns/1ps
module pix_mix_cfg
  import pix_mix_pkg::*;
#(
  parameter int PIX_W      = 32,
  parameter int LANE_W     = 8,
  parameter int FILL_LANES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [2:0]       addr,
  input  logic [PIX_W-1:0] wdata,
  output logic [PIX_W-1:0] fg_color,
  output logic [PIX_W-1:0] bg_color,
  output logic [PIX_W-1:0] wr_mask,
  output mix_ctrl_t        ctrl
);
  localparam int LANES = PIX_W / LANE_W;
  localparam int FILL_TOP = FILL_LANES * LANE_W;

  logic [PIX_W-1:0] fill_word;

  // Replicate the fill byte into the low lanes; upper lanes read zero.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g < FILL_LANES) begin : g_rep
      assign fill_word[g*LANE_W +: LANE_W] = wdata[LANE_W-1:0];
    end else begin : g_zero
      assign fill_word[g*LANE_W +: LANE_W] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fg_color <= '1;
      bg_color <= '0;
      wr_mask  <= '1;
      ctrl     <= CTRL_RESET;
    end else if (we) begin
      case (addr)
        ADDR_FG:   fg_color <= wdata;
        ADDR_BG:   bg_color <= wdata;
        ADDR_MASK: wr_mask  <= wdata;
        ADDR_CTRL: ctrl     <= mix_ctrl_t'({wdata[11:4], wdata[2:0]});
        ADDR_FILL: fg_color <= fill_word;
        default: ;
      endcase
    end
  end

  // R9: fill write leaves replicated lanes and zero upper bits
  a_r9_fill_replicate: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_FILL) |=>
      (fg_color[LANE_W-1:0] == $past(wdata[LANE_W-1:0])) &&
      (fg_color[2*LANE_W-1:LANE_W] == fg_color[LANE_W-1:0]) &&
      (fg_color[PIX_W-1:FILL_TOP] == '0));
endmodule

// File: rtl/pix_mix_srcsel.sv
`timescale 1ns/1ps
module pix_mix_srcsel
  import pix_mix_pkg::*;
#(
  parameter int PIX_W = 32
) (
  input  mix_ctrl_t        ctrl,
  input  logic [PIX_W-1:0] fg_color,
  input  logic [PIX_W-1:0] bg_color,
  input  logic             px_mono,
  input  logic [PIX_W-1:0] px_host,
  input  logic [PIX_W-1:0] px_blit,
  output logic             sel_fg,
  output logic [PIX_W-1:0] src_val,
  output logic [3:0]       mix_code
);
  logic [PIX_W-1:0] fg_src_val;

  always_comb begin
    case (ctrl.fg_src)
      FGS_HOST: fg_src_val = px_host;
      FGS_BLIT: fg_src_val = px_blit;
      default:  fg_src_val = fg_color;
    endcase
  end

  assign sel_fg   = ctrl.mono_host ? px_mono : 1'b1;
  assign src_val  = sel_fg ? fg_src_val : bg_color;
  assign mix_code = sel_fg ? ctrl.fg_mix : ctrl.bg_mix;
endmodule

// File: rtl/pix_mix_alu.sv
`timescale 1ns/1ps
module pix_mix_alu
  import pix_mix_pkg::*;
#(
  parameter int PIX_W = 32
) (
  input  logic [3:0]       mix_code,
  input  logic [PIX_W-1:0] src,
  input  logic [PIX_W-1:0] dst,
  input  logic [PIX_W-1:0] mask,
  output logic             mix_undef,
  output logic [PIX_W-1:0] result
);
  function automatic logic [PIX_W-1:0] mix_fn(input logic [3:0] code,
                                              input logic [PIX_W-1:0] s,
                                              input logic [PIX_W-1:0] d);
    case (code)
      MIX_SRC: return s;
      MIX_XOR: return d ^ s;
      default: return d;
    endcase
  endfunction

  function automatic logic [PIX_W-1:0] merge_fn(input logic [PIX_W-1:0] m,
                                                input logic [PIX_W-1:0] d,
                                                input logic [PIX_W-1:0] k);
    return (m & k) | (d & ~k);
  endfunction

  assign mix_undef = (mix_code != MIX_SRC) && (mix_code != MIX_XOR);
  assign result    = merge_fn(mix_fn(mix_code, src, dst), dst, mask);
endmodule

// File: rtl/pix_mix_unit.sv
`timescale 1ns/1ps
module pix_mix_unit
  import pix_mix_pkg::*;
#(
  parameter int PIX_W      = 32,
  parameter int LANE_W     = 8,
  parameter int FILL_LANES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [PIX_W-1:0] cfg_wdata,
  input  logic             px_valid,
  input  logic             px_mono,
  input  logic [PIX_W-1:0] px_host,
  input  logic [PIX_W-1:0] px_blit,
  input  logic [PIX_W-1:0] px_dst,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pixel
);
  logic [PIX_W-1:0] fg_color, bg_color, wr_mask;
  mix_ctrl_t        ctrl;
  logic             sel_fg;
  logic [PIX_W-1:0] src_val;
  logic [3:0]       mix_code;
  logic             mix_undef;
  logic [PIX_W-1:0] result;

  pix_mix_cfg #(.PIX_W(PIX_W), .LANE_W(LANE_W), .FILL_LANES(FILL_LANES)) cfg_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .fg_color(fg_color), .bg_color(bg_color), .wr_mask(wr_mask), .ctrl(ctrl)
  );

  pix_mix_srcsel #(.PIX_W(PIX_W)) sel_i (
    .ctrl(ctrl), .fg_color(fg_color), .bg_color(bg_color), .px_mono(px_mono),
    .px_host(px_host), .px_blit(px_blit), .sel_fg(sel_fg), .src_val(src_val),
    .mix_code(mix_code)
  );

  pix_mix_alu #(.PIX_W(PIX_W)) alu_i (
    .mix_code(mix_code), .src(src_val), .dst(px_dst), .mask(wr_mask),
    .mix_undef(mix_undef), .result(result)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pixel <= '0;
    end else begin
      out_valid <= px_valid;
      if (px_valid) out_pixel <= result;
    end
  end

  // R1: one-cycle valid pipeline
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |=> out_valid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !px_valid |=> !out_valid);
  // R2: output held while idle
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !px_valid |=> $stable(out_pixel));
  // R6: masked-off bits carry the old destination
  a_r6_mask_keeps_dst: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |=> ((out_pixel ^ $past(px_dst)) & ~$past(wr_mask)) == '0);
  // R5: undefined or destination mix codes pass destination through
  a_r5_undef_is_dst: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && mix_undef) |=> out_pixel == $past(px_dst));
  // R3: foreground path chosen whenever mono is forced to one
  a_r3_forced_fg: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && !ctrl.mono_host && ctrl.fg_mix == MIX_SRC && wr_mask == '1 &&
     ctrl.fg_src == FGS_HOST) |=> out_pixel == $past(px_host));
endmodule

// File: tb/pix_mix_unit_tb_top.sv
`timescale 1ns/1ps
module pix_mix_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        px_valid, px_mono;
  logic [31:0] px_host, px_blit, px_dst;
  logic        out_valid;
  logic [31:0] out_pixel;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] m_fg, m_bg, m_mask, prev_out;
  logic [11:0] m_ctl;

  always #2 clk = ~clk;

  pix_mix_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .px_valid(px_valid), .px_mono(px_mono),
    .px_host(px_host), .px_blit(px_blit), .px_dst(px_dst),
    .out_valid(out_valid), .out_pixel(out_pixel)
  );

  function automatic logic [31:0] expect_px(logic [31:0] fg, logic [31:0] bg,
      logic [31:0] mk, logic [11:0] ctl, logic mono, logic [31:0] host,
      logic [31:0] blit, logic [31:0] dst);
    logic use_fg;
    logic [31:0] s, r;
    logic [3:0] code;
    use_fg = ctl[2] ? mono : 1'b1;
    if (!use_fg) s = bg;
    else if (ctl[1:0] == 2'd1) s = host;
    else if (ctl[1:0] == 2'd2) s = blit;
    else s = fg;
    code = use_fg ? ctl[7:4] : ctl[11:8];
    if (code == 4'd1) r = s;
    else if (code == 4'd2) r = s ^ dst;
    else r = dst;
    return (dst & ~mk) | (r & mk);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_write(input logic [2:0] a, input logic [31:0] d);
    case (a)
      3'd0: m_fg = d;
      3'd1: m_bg = d;
      3'd2: m_mask = d;
      3'd3: m_ctl = d[11:0];
      3'd4: m_fg = {8'h00, d[7:0], d[7:0], d[7:0]};
      default: ;
    endcase
  endtask

  // One clock: drive at negedge, check at the following negedge.
  task automatic cycle(input string req, input bit we, input logic [2:0] a,
      input logic [31:0] d, input bit pv, input bit mono, input logic [31:0] host,
      input logic [31:0] blit, input logic [31:0] dst);
    logic [31:0] exp;
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
    px_valid = pv; px_mono = mono; px_host = host; px_blit = blit; px_dst = dst;
    exp = pv ? expect_px(m_fg, m_bg, m_mask, m_ctl, mono, host, blit, dst) : prev_out;
    @(posedge clk);
    if (we) model_write(a, d);
    @(negedge clk);
    check(out_valid == pv, "R1", {31'b0, out_valid}, {31'b0, pv});
    check(out_pixel == exp, pv ? req : "R2", out_pixel, exp);
    prev_out = out_pixel;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cycle("R11", 1'b1, a, d, 1'b0, 1'b0, '0, '0, '0);
  endtask

  task automatic px(input string req, input bit mono, input logic [31:0] host,
                    input logic [31:0] blit, input logic [31:0] dst);
    cycle(req, 1'b0, 3'd0, '0, 1'b1, mono, host, blit, dst);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    rst_n = 1'b0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    px_valid = 0; px_mono = 0; px_host = 0; px_blit = 0; px_dst = 0;
    m_fg = '1; m_bg = '0; m_mask = '1; m_ctl = 12'h010; prev_out = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(out_valid == 1'b0, "R1", {31'b0, out_valid}, 32'd0);
    check(out_pixel == '0, "R1", out_pixel, 32'd0);

    // R7: reset context overpaints with all-ones foreground
    px("R7", 1'b0, 32'h1234_5678, 32'h9abc_def0, 32'h0f0f_0f0f);
    check(out_pixel == 32'hffff_ffff, "R7", out_pixel, 32'hffff_ffff);
    cycle("R2", 0, 0, 0, 0, 0, 32'h5555_5555, 0, 32'haaaa_aaaa);

    // R9: fill replication
    wr(3'd4, 32'hdead_bea5);
    px("R9", 1'b0, 0, 0, 32'h7777_7777);
    check(out_pixel == 32'h00a5_a5a5, "R9", out_pixel, 32'h00a5_a5a5);

    // R4: source selects, including code 3
    wr(3'd3, 32'h011); px("R4", 0, 32'hcafe_0001, 32'hbeef_0002, 32'h0);
    wr(3'd3, 32'h012); px("R4", 0, 32'hcafe_0001, 32'hbeef_0002, 32'h0);
    wr(3'd3, 32'h013); px("R4", 0, 32'hcafe_0001, 32'hbeef_0002, 32'h0);

    // R3: monochrome expansion, both mixes source
    wr(3'd1, 32'h0000_1111); wr(3'd0, 32'h2222_0000);
    wr(3'd3, 32'h114);
    px("R3", 1'b1, 0, 0, 32'h3333_3333);
    px("R3", 1'b0, 0, 0, 32'h3333_3333);

    // R5: colour host image (fg XOR, bg destination), and undefined code
    wr(3'd3, 32'h021); px("R5", 0, 32'h0ff0_0ff0, 0, 32'hffff_0000);
    wr(3'd3, 32'h0f1); px("R5", 0, 32'h0ff0_0ff0, 0, 32'h1357_9bdf);
    wr(3'd3, 32'h934); px("R5", 0, 0, 0, 32'h2468_ace0);

    // R6: partial write mask
    wr(3'd3, 32'h011); wr(3'd2, 32'h0000_ffff);
    px("R6", 0, 32'haaaa_aaaa, 0, 32'h5555_5555);

    // R10: unused addresses change nothing
    wr(3'd5, 32'h0); wr(3'd6, 32'h0); wr(3'd7, 32'h0);
    px("R10", 0, 32'haaaa_aaaa, 0, 32'h5555_5555);

    // R11: write and pixel in the same cycle use the old setting
    cycle("R11", 1'b1, 3'd2, 32'hffff_ffff, 1'b1, 0, 32'h1111_2222, 0, 32'h3333_4444);
    px("R11", 0, 32'h1111_2222, 0, 32'h3333_4444);
    // R8: each address reaches its own register
    wr(3'd0, 32'h0bad_f00d); wr(3'd3, 32'h010);
    px("R8", 0, 0, 0, 32'h0);

    // Constrained random mix
    for (int i = 0; i < 600; i++) begin
      int kind;
      logic [31:0] d;
      kind = $urandom_range(0, 9);
      d = $urandom;
      if (kind < 3) begin
        logic [2:0] a;
        a = 3'($urandom_range(0, 7));
        cycle("R8", 1'b1, a, d, kind == 0, 1'($urandom), $urandom, $urandom, $urandom);
      end else if (kind == 3) begin
        cycle("R2", 1'b0, 3'd0, '0, 1'b0, 1'($urandom), $urandom, $urandom, $urandom);
      end else begin
        px("R5", 1'($urandom), $urandom, $urandom, $urandom);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule